// File: doc/BRIEF.md
# Interface reset conformance monitor

This block is a passive observer that sits beside an AXI4, AXI3 or AXI4-Lite port. It samples the bus reset line (active low) and the five handshake READY signals on every rising clock edge. It drives nothing on the bus. Its only outputs are sticky violation flags, one for each rule.

Two rules are enforced:

- **Reset pulse width.** A low pulse on the bus reset must span at least a minimum number of sampled clock cycles, 16 by default. The length of each low pulse is judged on the clock edge where the line is first seen high again.
- **READY low after release.** On that same first high-sampled edge, every READY signal must be low. This covers the three that the subordinate drives (write address, write data and read address) and the two that the manager drives (write response and read data).

The monitor has its own synchronous active-low reset, which is separate from the bus reset it watches. Flags survive any number of bus resets, so a testbench or a debug path can read them at the end of a run. A parameter decides how the low level that may be present at power-up is treated. With the default setting, that level is not judged for width, because its start was never seen. Setting the parameter to 1 makes the monitor judge it too, counting from the release of the monitor's own reset.

Top module: `axi_reset_monitor`

## Requirements
- R1: While `mon_rst_n` is low and in the cycle after it returns high, all six bits of `viol` read 0.
- R2: A bus reset pulse that `clk` samples low on exactly `MIN_LOW_CYCLES` (default 16) consecutive edges, and which then returns high, leaves `viol[0]` at 0.
- R3: A bus reset pulse that is sampled low on fewer than `MIN_LOW_CYCLES` edges, and which starts after a high sample, sets `viol[0]` on the edge where `bus_rst_n` is first sampled high. This includes a pulse of a single cycle.
- R4: A bus reset pulse that is sampled low on far more than `MIN_LOW_CYCLES` edges (for example 40) leaves `viol[0]` at 0. The internal count stops at `MIN_LOW_CYCLES` and never wraps.
- R5: With `CHECK_INITIAL_PULSE = 0` (the default), a low level on `bus_rst_n` that is present when the monitor leaves its own reset, and that has no preceding high sample, is not judged for width. Releasing it after 5 cycles leaves `viol[0]` at 0.
- R6: A READY that is sampled high on the first edge where `bus_rst_n` is sampled high sets its own flag. The flag positions are `viol[1]` write address, `viol[2]` write data, `viol[3]` write response, `viol[4]` read address and `viol[5]` read data.
- R7: A READY that is high only while the bus reset is low, or only from the second high-sampled edge onward, sets no flag.
- R8: Every `viol` bit, once set, stays set through later bus resets, whether they are long or short. Only `mon_rst_n` low clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| mon_rst_n | input | 1 | Synchronous active-low reset of the monitor itself; clears all flags |
| bus_rst_n | input | 1 | Observed bus reset, active low |
| aw_ready | input | 1 | Observed write-address READY |
| w_ready | input | 1 | Observed write-data READY |
| b_ready | input | 1 | Observed write-response READY |
| ar_ready | input | 1 | Observed read-address READY |
| r_ready | input | 1 | Observed read-data READY |
| viol | output | 6 | Sticky flags: [0] short reset pulse, [5:1] READY high after release, per R6 |

## Verification
The bench tests pulses of 15 and 16 sampled cycles. An off-by-one counter would either miss the short one or flag the legal one. A 40-cycle pulse catches a counter that wraps instead of saturating, since such a counter would flag a long, legal pulse.

A single-cycle pulse tests how the count restarts on a falling edge. If the stale count from the previous pulse carried over, the short pulse would pass unseen.

Each READY is raised alone on the release edge to prove the flag positions. READY is also held high during reset and raised one cycle late. A monitor that checked the wrong cycle would flag those cases and miss the real one.

Finally, a power-up low level is released early, and several legal pulses follow a violation. A monitor with no notion of an observed falling edge would report the power-up level, and one whose flags were not sticky would lose earlier reports.

// File: rtl/axi_rstmon_pkg.sv
// Shared constants for the interface reset conformance monitor.
// Assumes the flag vector layout: bit 0 pulse width, bits 1..5 READY lanes.
package axi_rstmon_pkg;
    localparam int NUM_READY = 5;
    localparam int NUM_FLAGS = NUM_READY + 1;

    // Flag positions inside the violation vector.
    typedef enum int {
        FLG_PULSE = 0,
        FLG_AW    = 1,
        FLG_W     = 2,
        FLG_B     = 3,
        FLG_AR    = 4,
        FLG_R     = 5
    } flag_idx_e;
endpackage

// File: rtl/rstmon_edge.sv
// Edge detector for the observed bus reset line.
// Keeps the previous sample and a valid bit, so that the first sample
// after the monitor's own reset never looks like an edge.
// Assumes bus_rst_n is already synchronous to clk.
module rstmon_edge (
    input  logic clk,
    input  logic mon_rst_n,
    input  logic bus_rst_n,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;
    logic prev_vld_q;

    // Remember the last sample of the bus reset and whether it is meaningful.
    always_ff @(posedge clk) begin
        if (!mon_rst_n) begin
            prev_q     <= 1'b0;
            prev_vld_q <= 1'b0;
        end else begin
            prev_q     <= bus_rst_n;
            prev_vld_q <= 1'b1;
        end
    end

    // An edge is a change between two valid consecutive samples.
    always_comb begin
        rise_o = prev_vld_q && !prev_q &&  bus_rst_n;
        fall_o = prev_vld_q &&  prev_q && !bus_rst_n;
    end
endmodule

// File: rtl/rstmon_pulse.sv
// Measures each low pulse of the bus reset with a saturating counter and
// raises a sticky flag when a pulse ends before MIN_LOW_CYCLES samples.
// Assumes the edge strobes come from rstmon_edge on the same clock.
module rstmon_pulse #(
    parameter int MIN_LOW_CYCLES      = 16,
    parameter bit CHECK_INITIAL_PULSE = 1'b0
) (
    input  logic clk,
    input  logic mon_rst_n,
    input  logic bus_rst_n,
    input  logic rise_i,
    input  logic fall_i,
    output logic short_o
);
    localparam int              CNT_W   = $clog2(MIN_LOW_CYCLES + 1);
    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_LOW_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             short_q;

    // Count consecutive low samples, restarting at every observed falling edge.
    always_ff @(posedge clk) begin
        if (!mon_rst_n) begin
            cnt_q <= '0;
        end else if (fall_i) begin
            cnt_q <= CNT_W'(1);
        end else if (!bus_rst_n && cnt_q != MIN_CNT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Arm width checking once a pulse with a seen start has begun.
    always_ff @(posedge clk) begin
        if (!mon_rst_n) begin
            armed_q <= CHECK_INITIAL_PULSE;
        end else if (fall_i) begin
            armed_q <= 1'b1;
        end
    end

    // Judge the pulse length on release and keep any violation.
    always_ff @(posedge clk) begin
        if (!mon_rst_n) begin
            short_q <= 1'b0;
        end else if (rise_i && armed_q && cnt_q < MIN_CNT) begin
            short_q <= 1'b1;
        end
    end

    assign short_o = short_q;

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!mon_rst_n)
        cnt_q <= MIN_CNT);

    assert_long_pulse_clean_R2: assert property (@(posedge clk) disable iff (!mon_rst_n)
        (rise_i && cnt_q == MIN_CNT && !short_q) |=> !short_q);

    assert_flag_on_release_R3: assert property (@(posedge clk) disable iff (!mon_rst_n)
        $rose(short_q) |-> $past(rise_i));

    assert_sticky_pulse_R8: assert property (@(posedge clk) disable iff (!mon_rst_n)
        short_q |=> short_q);
endmodule

// File: rtl/rstmon_ready.sv
// Checks one READY lane: it must be low on the first edge at which the bus
// reset is sampled high. A violation is held until the monitor is reset.
// Assumes rise_i marks exactly that edge.
module rstmon_ready (
    input  logic clk,
    input  logic mon_rst_n,
    input  logic rise_i,
    input  logic ready_i,
    output logic flag_o
);
    logic flag_q;

    // Capture READY high on the release edge and hold it.
    always_ff @(posedge clk) begin
        if (!mon_rst_n) begin
            flag_q <= 1'b0;
        end else if (rise_i && ready_i) begin
            flag_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    assert_ready_caught_R6: assert property (@(posedge clk) disable iff (!mon_rst_n)
        (rise_i && ready_i) |=> flag_q);

    assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!mon_rst_n)
        $rose(flag_q) |-> $past(rise_i && ready_i));

    assert_sticky_ready_R8: assert property (@(posedge clk) disable iff (!mon_rst_n)
        flag_q |=> flag_q);
endmodule

// File: rtl/axi_reset_monitor.sv
// Top of the interface reset conformance monitor. It is purely passive: it
// samples the bus reset and the five READY lines and reports sticky flags.
// Assumes all inputs are synchronous to clk. mon_rst_n is the monitor's
// own synchronous reset and is independent of the bus reset.
module axi_reset_monitor
    import axi_rstmon_pkg::*;
#(
    parameter int MIN_LOW_CYCLES      = 16,
    parameter bit CHECK_INITIAL_PULSE = 1'b0
) (
    input  logic                 clk,
    input  logic                 mon_rst_n,
    input  logic                 bus_rst_n,
    input  logic                 aw_ready,
    input  logic                 w_ready,
    input  logic                 b_ready,
    input  logic                 ar_ready,
    input  logic                 r_ready,
    output logic [NUM_FLAGS-1:0] viol
);
    logic                 rise;
    logic                 fall;
    logic [NUM_READY-1:0] rdy_vec;

    // Gather the READY lanes in flag order: AW, W, B, AR, R.
    always_comb begin
        rdy_vec[FLG_AW - 1] = aw_ready;
        rdy_vec[FLG_W  - 1] = w_ready;
        rdy_vec[FLG_B  - 1] = b_ready;
        rdy_vec[FLG_AR - 1] = ar_ready;
        rdy_vec[FLG_R  - 1] = r_ready;
    end

    rstmon_edge u_edge (
        .clk       (clk),
        .mon_rst_n (mon_rst_n),
        .bus_rst_n (bus_rst_n),
        .rise_o    (rise),
        .fall_o    (fall)
    );

    rstmon_pulse #(
        .MIN_LOW_CYCLES      (MIN_LOW_CYCLES),
        .CHECK_INITIAL_PULSE (CHECK_INITIAL_PULSE)
    ) u_pulse (
        .clk       (clk),
        .mon_rst_n (mon_rst_n),
        .bus_rst_n (bus_rst_n),
        .rise_i    (rise),
        .fall_i    (fall),
        .short_o   (viol[FLG_PULSE])
    );

    for (genvar i = 0; i < NUM_READY; i++) begin : g_lane
        rstmon_ready u_ready (
            .clk       (clk),
            .mon_rst_n (mon_rst_n),
            .rise_i    (rise),
            .ready_i   (rdy_vec[i]),
            .flag_o    (viol[i+1])
        );
    end

    assert_no_edge_overlap_R3: assert property (@(posedge clk) disable iff (!mon_rst_n)
        !(rise && fall));

    assert_clear_after_reset_R1: assert property (@(posedge clk)
        !mon_rst_n |=> viol == '0);
endmodule

// File: tb/sim_axi_reset_monitor.sv
module sim_axi_reset_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_LOW    = 16;

    logic       clk = 1'b0;
    logic       mon_rst_n;
    logic       bus_rst_n;
    logic [4:0] rdy;          // 0 AW, 1 W, 2 B, 3 AR, 4 R
    logic [5:0] viol;
    int         checks = 0;
    int         fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    axi_reset_monitor #(.MIN_LOW_CYCLES(MIN_LOW), .CHECK_INITIAL_PULSE(1'b0)) u0 (
        .clk       (clk),
        .mon_rst_n (mon_rst_n),
        .bus_rst_n (bus_rst_n),
        .aw_ready  (rdy[0]),
        .w_ready   (rdy[1]),
        .b_ready   (rdy[2]),
        .ar_ready  (rdy[3]),
        .r_ready   (rdy[4]),
        .viol      (viol)
    );

    task automatic check(input string req, input logic [5:0] exp);
        checks++;
        if (viol !== exp) begin
            fails++;
            $display("FAIL %s: viol=%b expected %b", req, viol, exp);
        end
    endtask

    // Reset the monitor with bus_rst_n held at lvl; returns at a negedge.
    task automatic mon_reset(input logic lvl);
        @(negedge clk);
        mon_rst_n = 1'b0; bus_rst_n = lvl; rdy = '0;
        repeat (2) @(negedge clk);
        check("R1", 6'b0);
        mon_rst_n = 1'b1;
        @(negedge clk);
        check("R1", 6'b0);
        bus_rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Bus reset low for n samples, then release with READY vector rv on the
    // first high edge; returns one negedge after that edge.
    task automatic pulse(input int n, input logic [4:0] rv_low, input logic [4:0] rv);
        bus_rst_n = 1'b0; rdy = rv_low;
        repeat (n) @(negedge clk);
        bus_rst_n = 1'b1; rdy = rv;
        @(negedge clk);
        rdy = '0;
    endtask

    task automatic t_powerup;
        @(negedge clk);
        mon_rst_n = 1'b0; bus_rst_n = 1'b0; rdy = '0;
        repeat (3) @(negedge clk);
        check("R1", 6'b0);
        mon_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_rst_n = 1'b1;
        @(negedge clk);
        check("R5", 6'b0);
        @(negedge clk);
    endtask

    task automatic t_widths;
        pulse(MIN_LOW, '0, '0);
        check("R2", 6'b0);
        pulse(40, '0, '0);
        check("R4", 6'b0);
        pulse(MIN_LOW, 5'b11111, '0);
        rdy = 5'b11111;
        @(negedge clk);
        rdy = '0;
        check("R7", 6'b0);
        pulse(MIN_LOW - 1, '0, '0);
        check("R3", 6'b000001);
        pulse(MIN_LOW, '0, '0);
        check("R8", 6'b000001);
    endtask

    task automatic t_single;
        mon_reset(1'b1);
        pulse(40, '0, '0);
        pulse(1, '0, '0);
        check("R3", 6'b000001);
    endtask

    task automatic t_lanes;
        for (int i = 0; i < 5; i++) begin
            mon_reset(1'b1);
            pulse(20, '0, 5'(1 << i));
            check("R6", 6'(2 << i));
            pulse(MIN_LOW, '0, '0);
            check("R8", 6'(2 << i));
        end
        mon_reset(1'b1);
        pulse(3, '0, 5'b10100);
        check("R6", 6'b101001);
        pulse(30, '0, '0);
        check("R8", 6'b101001);
    endtask

    initial begin
        mon_rst_n = 1'b0; bus_rst_n = 1'b0; rdy = '0;
        t_powerup;
        t_widths;
        t_single;
        t_lanes;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule